// File: doc/BRIEF.md
# Boot Strap Capture and Bank Select Decoder

This block records the boot-configuration strap pins while power-on reset is held and freezes them when reset is released. The frozen straps say whether the boot device sits behind the synchronous or the asynchronous memory controller, and how wide its data bus is. From them the block derives a bus-width code, a ROM/flash flag for synchronous devices, and a request to program the synchronous device's mode register.

Every 32-bit address presented on the input stream is turned into one result on the output stream. The four top address bits pick a 256 MB region. Regions 0x0 to 0x7 are the eight asynchronous banks, 0x8 is the on-chip internal/register region, 0x9 to 0xB are unused, and 0xC to 0xF are the four synchronous banks. The result carries a one-hot bank select, the 28-bit offset inside the bank, a flag for the two card-slot banks, an internal-region flag and a decode-error flag.

After reset, address zero is aliased to the boot bank. Software ends the alias with a one-cycle clear pulse, and the alias stays off until the next power-on reset. Both streams use valid/ready. An address is taken on a clock edge where `addr_valid` and `addr_ready` are both high. A result stays on the output, unchanged, until it is taken on an edge where `sel_valid` and `sel_ready` are both high. `addr_ready` is high whenever the output register is empty or is being emptied in the same cycle.

Top module: `bootmap_decode`

## Requirements
- R1: While `por_n` is low the straps are sampled on every clock edge. From the first edge with `por_n` high, the boot outputs keep their values whatever the strap pins do, until `por_n` goes low again.
- R2: With `strap_sync`=0 (asynchronous boot), `boot_width` follows the width straps as follows: strap 00 gives code 0 (8-bit), strap 01 gives code 1 (16-bit), and strap 10 or 11 gives code 2 (32-bit). In this mode `boot_srom` and `mode_init_req` are 0.
- R3: With `strap_sync`=1 (synchronous boot), `strap_width[1]` picks the width: 0 gives code 1 (16-bit) and 1 gives code 2 (32-bit). `strap_width[0]`=1 marks a ROM device (`boot_srom`=1) and 0 marks a flash device. `mode_init_req` is 1 in every synchronous mode.
- R4: An address with top nibble 0x0 to 0x7 (and no alias active) selects `bank_sel` bit equal to that nibble. `bank_offset` equals `addr[27:0]`.
- R5: An address with top nibble 0xC to 0xF selects `bank_sel` bit 8 to 11, that is, the nibble minus 4. `bank_offset` equals `addr[27:0]`.
- R6: `sel_card` is 1 exactly when the selected bank is asynchronous bank 6 or 7.
- R7: Top nibble 0x8 gives `sel_internal`=1 with no bank selected. Top nibbles 0x9 to 0xB give `dec_err`=1, no bank selected and `bank_offset`=0.
- R8: While the alias is on after synchronous boot, top nibble 0x0 selects `bank_sel` bit 11, the fourth synchronous bank. After asynchronous boot, top nibble 0x0 selects bit 0.
- R9: A `remap_clr` pulse turns the alias off from the next edge onward, so that nibble 0x0 selects bit 0. A later power-on reset turns the alias back on.
- R10: A result appears on the output on the edge that accepts its address. It is held stable while `sel_ready` is low. `sel_valid` is 0 during reset.
- R11: Every valid result has exactly one of these: a single `bank_sel` bit, `sel_internal`, or `dec_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| strap_sync | input | 1 | Boot strap: 1 = synchronous boot device |
| strap_width | input | 2 | Boot strap: device width code |
| remap_clr | input | 1 | One-cycle pulse that ends the address-zero alias |
| addr_valid | input | 1 | Address stream valid |
| addr_ready | output | 1 | Address stream ready |
| addr | input | 32 | Address to decode |
| sel_valid | output | 1 | Result stream valid |
| sel_ready | input | 1 | Result stream ready |
| bank_sel | output | 12 | One-hot bank select: bits 0-7 asynchronous, 8-11 synchronous |
| bank_offset | output | 28 | Offset inside the selected region |
| sel_card | output | 1 | Selected bank is a card-slot bank |
| sel_internal | output | 1 | Internal/register region selected |
| dec_err | output | 1 | Address falls in an unused region |
| boot_sync | output | 1 | Latched synchronous-boot flag |
| boot_width | output | 2 | Latched width: 0 = 8, 1 = 16, 2 = 32 bits |
| boot_srom | output | 1 | Synchronous boot device is ROM |
| mode_init_req | output | 1 | Mode-register initialization requested |

## Verification
The boot outputs are valid at the first falling edge after any reset edge. The bench checks them only after `por_n` has risen and the strap pins have been changed, so a check can only pass if the design has ignored the new pin values. A decode result becomes valid one edge after its address is accepted and then waits for `sel_ready`. For that reason the driver records the expected result at acceptance, and the monitor compares it only when a transfer is seen at the falling edge, with `sel_ready` pulled low at intervals to create stalls. A `remap_clr` pulse affects addresses accepted from the following edge onward, so the bench lets one full cycle pass before it sends the next address.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  localparam int ADDR_W    = 32;
  localparam int REGION_W  = 4;
  localparam int N_ASYNC   = 8;
  localparam int N_SYNC    = 4;
  localparam int INT_REGION  = 8;
  localparam int SYNC_REGION = 12;
  localparam int CARD_FIRST  = 6;
  localparam int CARD_COUNT  = 2;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2
  } bus_width_e;
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import bootmap_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_sync,
  input  logic [1:0] pin_width,
  input  logic       remap_clr,
  output logic       boot_sync,
  output bus_width_e boot_width,
  output logic       boot_srom,
  output logic       mode_init_req,
  output logic       remap_on
);
  logic       sync_q;
  logic [1:0] wid_q;
  logic       remap_q;

  // Straps follow the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!por_n) begin
      sync_q  <= pin_sync;
      wid_q   <= pin_width;
      remap_q <= 1'b1;
    end else if (remap_clr) begin
      remap_q <= 1'b0;
    end
  end

  always_comb begin
    if (sync_q) begin
      boot_width = wid_q[1] ? BW_32 : BW_16;
      boot_srom  = wid_q[0];
    end else begin
      boot_srom  = 1'b0;
      unique case (wid_q)
        2'b00:   boot_width = BW_8;
        2'b01:   boot_width = BW_16;
        default: boot_width = BW_32;
      endcase
    end
  end

  assign boot_sync     = sync_q;
  assign mode_init_req = sync_q;
  assign remap_on      = remap_q;
endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int ADDR_W      = 32,
  parameter int REGION_W    = 4,
  parameter int N_ASYNC     = 8,
  parameter int N_SYNC      = 4,
  parameter int INT_REGION  = 8,
  parameter int SYNC_REGION = 12,
  parameter int CARD_FIRST  = 6,
  parameter int CARD_COUNT  = 2,
  localparam int OFF_W      = ADDR_W - REGION_W,
  localparam int N_BANK     = N_ASYNC + N_SYNC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_sync,
  input  logic              remap_on,
  output logic [N_BANK-1:0] sel,
  output logic [OFF_W-1:0]  offset,
  output logic              card,
  output logic              intl,
  output logic              err
);
  logic [REGION_W-1:0] region;
  logic                alias_hit;

  assign region    = addr[ADDR_W-1 -: REGION_W];
  assign alias_hit = remap_on && boot_sync && (region == '0);

  genvar gi;
  generate
    for (gi = 0; gi < N_ASYNC; gi++) begin : g_async
      if (gi == 0) begin : g_zero
        assign sel[gi] = (region == REGION_W'(gi)) && !alias_hit;
      end else begin : g_rest
        assign sel[gi] = (region == REGION_W'(gi));
      end
    end
    for (gi = 0; gi < N_SYNC; gi++) begin : g_sync
      if (gi == N_SYNC - 1) begin : g_boot
        assign sel[N_ASYNC+gi] = (region == REGION_W'(SYNC_REGION + gi)) || alias_hit;
      end else begin : g_plain
        assign sel[N_ASYNC+gi] = (region == REGION_W'(SYNC_REGION + gi));
      end
    end
  endgenerate

  assign intl   = (region == REGION_W'(INT_REGION));
  assign err    = !(|sel) && !intl;
  assign card   = |sel[CARD_FIRST +: CARD_COUNT];
  assign offset = err ? '0 : addr[OFF_W-1:0];
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/bootmap_decode.sv
module bootmap_decode
  import bootmap_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int RW         = REGION_W,
  parameter int NA         = N_ASYNC,
  parameter int NS         = N_SYNC,
  localparam int OW        = AW - RW,
  localparam int NB        = NA + NS,
  localparam int PW        = NB + OW + 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          strap_sync,
  input  logic [1:0]    strap_width,
  input  logic          remap_clr,
  input  logic          addr_valid,
  output logic          addr_ready,
  input  logic [AW-1:0] addr,
  output logic          sel_valid,
  input  logic          sel_ready,
  output logic [NB-1:0] bank_sel,
  output logic [OW-1:0] bank_offset,
  output logic          sel_card,
  output logic          sel_internal,
  output logic          dec_err,
  output logic          boot_sync,
  output logic [1:0]    boot_width,
  output logic          boot_srom,
  output logic          mode_init_req
);
  bus_width_e    width_e;
  logic          remap_on;
  logic [NB-1:0] d_sel;
  logic [OW-1:0] d_off;
  logic          d_card, d_intl, d_err;
  logic [PW-1:0] q_bus;

  strap_latch u_straps (
    .clk          (clk),
    .por_n        (por_n),
    .pin_sync     (strap_sync),
    .pin_width    (strap_width),
    .remap_clr    (remap_clr),
    .boot_sync    (boot_sync),
    .boot_width   (width_e),
    .boot_srom    (boot_srom),
    .mode_init_req(mode_init_req),
    .remap_on     (remap_on)
  );
  assign boot_width = width_e;

  bank_decode #(
    .ADDR_W     (AW),
    .REGION_W   (RW),
    .N_ASYNC    (NA),
    .N_SYNC     (NS),
    .INT_REGION (INT_REGION),
    .SYNC_REGION(SYNC_REGION),
    .CARD_FIRST (CARD_FIRST),
    .CARD_COUNT (CARD_COUNT)
  ) u_dec (
    .addr     (addr),
    .boot_sync(boot_sync),
    .remap_on (remap_on),
    .sel      (d_sel),
    .offset   (d_off),
    .card     (d_card),
    .intl     (d_intl),
    .err      (d_err)
  );

  out_stage #(.W(PW)) u_out (
    .clk      (clk),
    .rst_n    (por_n),
    .in_valid (addr_valid),
    .in_ready (addr_ready),
    .in_data  ({d_sel, d_off, d_card, d_intl, d_err}),
    .out_valid(sel_valid),
    .out_ready(sel_ready),
    .out_data (q_bus)
  );

  assign {bank_sel, bank_offset, sel_card, sel_internal, dec_err} = q_bus;
endmodule

// File: rtl/bootmap_decode_chk.sv
module bootmap_decode_chk (
  input logic        clk,
  input logic        por_n,
  input logic        addr_valid,
  input logic        addr_ready,
  input logic        sel_valid,
  input logic        sel_ready,
  input logic [11:0] bank_sel,
  input logic [27:0] bank_offset,
  input logic        sel_card,
  input logic        sel_internal,
  input logic        dec_err,
  input logic        boot_sync,
  input logic [1:0]  boot_width,
  input logic        mode_init_req
);
  p_straps_frozen_r1: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> ($stable(boot_sync) && $stable(boot_width)));

  p_init_follows_sync_r3: assert property (@(posedge clk) disable iff (!por_n)
    mode_init_req == boot_sync);

  p_card_bank_r6: assert property (@(posedge clk) disable iff (!por_n)
    (sel_valid && sel_card) |-> (bank_sel[6] || bank_sel[7]));

  p_err_no_bank_r7: assert property (@(posedge clk) disable iff (!por_n)
    (sel_valid && dec_err) |-> (bank_sel == 12'd0 && bank_offset == 28'd0));

  p_accept_to_valid_r10: assert property (@(posedge clk) disable iff (!por_n)
    (addr_valid && addr_ready) |=> sel_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
    (sel_valid && !sel_ready) |=> (sel_valid && $stable(bank_sel) && $stable(bank_offset)
                                   && $stable(dec_err) && $stable(sel_internal)));

  p_one_target_r11: assert property (@(posedge clk) disable iff (!por_n)
    sel_valid |-> ($onehot0(bank_sel) && $countones({|bank_sel, sel_internal, dec_err}) == 1));
endmodule

bind bootmap_decode bootmap_decode_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .addr_valid   (addr_valid),
  .addr_ready   (addr_ready),
  .sel_valid    (sel_valid),
  .sel_ready    (sel_ready),
  .bank_sel     (bank_sel),
  .bank_offset  (bank_offset),
  .sel_card     (sel_card),
  .sel_internal (sel_internal),
  .dec_err      (dec_err),
  .boot_sync    (boot_sync),
  .boot_width   (boot_width),
  .mode_init_req(mode_init_req)
);

// File: tb/sim_bootmap_decode.sv
module sim_bootmap_decode;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        strap_sync = 1'b0;
  logic [1:0]  strap_width = 2'b00;
  logic        remap_clr = 1'b0;
  logic        addr_valid = 1'b0;
  logic        addr_ready;
  logic [31:0] addr = '0;
  logic        sel_valid;
  logic        sel_ready = 1'b1;
  logic [11:0] bank_sel;
  logic [27:0] bank_offset;
  logic        sel_card, sel_internal, dec_err;
  logic        boot_sync, boot_srom, mode_init_req;
  logic [1:0]  boot_width;

  always #(PERIOD/2) clk = ~clk;

  bootmap_decode u0 (
    .clk(clk), .por_n(por_n), .strap_sync(strap_sync), .strap_width(strap_width),
    .remap_clr(remap_clr), .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .bank_sel(bank_sel),
    .bank_offset(bank_offset), .sel_card(sel_card), .sel_internal(sel_internal),
    .dec_err(dec_err), .boot_sync(boot_sync), .boot_width(boot_width),
    .boot_srom(boot_srom), .mode_init_req(mode_init_req)
  );

  typedef struct packed {
    logic [11:0] sel;
    logic [27:0] off;
    logic        card;
    logic        intl;
    logic        err;
    logic [3:0]  tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   m_sync = 0;
  bit   m_remap = 1;
  bit   stall_en = 1;
  bit   done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each result as it leaves the design.
  always @(negedge clk) begin
    if (por_n && sel_valid && sel_ready) begin
      if (q.size() == 0) begin
        chk("R10 unexpected result", 1, 0);
      end else begin
        exp_t e;
        string rq;
        e = q.pop_front();
        rq = $sformatf("R%0d result", e.tag);
        chk(rq, {bank_sel, bank_offset, sel_card, sel_internal, dec_err},
                {e.sel, e.off, e.card, e.intl, e.err});
      end
    end
  end

  // Back-pressure: drop sel_ready one cycle in three.
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 sel_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  function automatic exp_t model(input logic [31:0] a, input logic [3:0] tag);
    exp_t e;
    int   rg;
    rg = int'(a[31:28]);
    e = '0;
    e.tag = tag;
    e.off = a[27:0];
    if (rg == 0 && m_remap && m_sync)  e.sel[11] = 1'b1;       // R8
    else if (rg < 8)                   e.sel[rg] = 1'b1;       // R4
    else if (rg == 8)                  e.intl = 1'b1;          // R7
    else if (rg >= 12)                 e.sel[rg-4] = 1'b1;     // R5
    else begin e.err = 1'b1; e.off = '0; end                  // R7
    e.card = e.sel[6] | e.sel[7];                             // R6
    return e;
  endfunction

  task automatic send(input logic [31:0] a, input logic [3:0] tag);
    @(posedge clk); #1;
    addr = a;
    addr_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (addr_ready) break;
    end
    q.push_back(model(a, tag));
    @(posedge clk); #1;
    addr_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || sel_valid) @(negedge clk);
  endtask

  task automatic power_on(input bit s, input logic [1:0] w);
    drain();
    @(posedge clk); #1;
    por_n = 1'b0;
    strap_sync = s;
    strap_width = w;
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;
    m_sync = s;
    m_remap = 1;
    // R1: move the pins after release; latched values must not follow.
    strap_sync = ~s;
    strap_width = ~w;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_mode(input string req, input bit s, input logic [1:0] w,
                          input bit rom);
    chk({req, " boot_sync"}, boot_sync, s);
    chk({req, " boot_width"}, boot_width, w);
    chk({req, " boot_srom"}, boot_srom, rom);
    chk({req, " mode_init_req"}, mode_init_req, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // Reset state, R10
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 sel_valid in reset", sel_valid, 0);

    // Asynchronous boot, 8-bit device (R1, R2)
    power_on(0, 2'b00);
    chk_mode("R1 R2 async 00", 0, 2'd0, 0);

    send(32'h0000_1234, 8);   // R8 async: bank 0
    send(32'h3ABC_0000, 4);   // R4
    send(32'h5FFF_FFFF, 4);   // R4
    send(32'h6000_0010, 6);   // R6 card bank
    send(32'h7FFF_FFFF, 6);   // R6
    send(32'h8000_0004, 7);   // R7 internal
    send(32'h9000_0000, 7);   // R7 unused
    send(32'hB123_4567, 7);   // R7 unused
    send(32'hC000_0000, 5);   // R5
    send(32'hF123_4567, 5);   // R5
    send(32'hDEAD_BEEF, 11);  // R11
    drain();

    // R10 latency: one edge from acceptance to valid, ready held high
    stall_en = 0;
    @(posedge clk); #1;
    addr = 32'h2000_0040;
    addr_valid = 1'b1;
    q.push_back(model(32'h2000_0040, 10));
    @(posedge clk); #1;
    addr_valid = 1'b0;
    @(negedge clk);
    chk("R10 valid one edge after accept", sel_valid, 1);
    drain();
    stall_en = 1;

    // R2 remaining codes
    power_on(0, 2'b11);
    chk_mode("R2 async 11", 0, 2'd2, 0);
    power_on(0, 2'b01);
    chk_mode("R2 async 01", 0, 2'd1, 0);
    power_on(0, 2'b10);
    chk_mode("R2 async 10", 0, 2'd2, 0);

    // Synchronous boot, 16-bit flash (R3) with alias (R8)
    power_on(1, 2'b00);
    chk_mode("R3 sync 00", 1, 2'd1, 0);
    send(32'h0000_0100, 8);   // R8 alias to sync bank 3
    send(32'h0FFF_FFFC, 8);   // R8
    send(32'hF000_0008, 5);   // R5 real bank still reachable
    drain();

    // R9 clear alias
    @(posedge clk); #1 remap_clr = 1'b1;
    @(posedge clk); #1 remap_clr = 1'b0;
    m_remap = 0;
    send(32'h0000_0100, 9);   // R9 now bank 0
    send(32'h0400_0000, 9);
    drain();

    // R9 alias returns after power-on reset; R3 ROM variants
    power_on(1, 2'b11);
    chk_mode("R3 sync 11", 1, 2'd2, 1);
    send(32'h0000_0200, 9);   // R9 alias back on
    power_on(1, 2'b01);
    chk_mode("R3 sync 01", 1, 2'd1, 1);
    power_on(1, 2'b10);
    chk_mode("R3 sync 10", 1, 2'd2, 0);
    send(32'hA000_0000, 11);  // R11 only dec_err
    drain();

    chk("R10 scoreboard empty", q.size(), 0);
    finish_run();
  end
endmodule